// File: doc/BRIEF.md
# Paired Output Compare Unit

This block holds two compare channels that share one control register and drive two output pins, an even pin and an odd pin. Software writes a match value into each channel's compare register. Channel 0 watches the count of timer A. Channel 1 watches the count of timer B. Each timer comes from outside the block with a count-enable strobe. A channel registers a match when its enable bit is set, its timer's strobe is high, and the timer count equals the stored compare value.

The even pin is inverted only by channel 0 matches. A mode bit selects how the odd pin behaves. With the mode bit clear, the odd pin follows only channel 1 matches. With the mode bit set, matches of either channel invert it. Each channel also keeps a sticky flag, and these flags drive an interrupt request. While a channel is disabled, software can load its pin level directly. A small write/read port gives access to the two compare registers and the control register.

Top module: `paired_ocmp`

## Requirements
- R1: Address 0 holds compare register 0 and address 1 holds compare register 1. Both are CNT_W bits wide and read back the last value written. A value written in one cycle is used for comparison from the next cycle on.
- R2: The even pin inverts one cycle after a channel 0 match, whatever the mode bit is set to. Channel 1 matches have no effect on it.
- R3: With the mode bit (control bit 2) clear, the odd pin inverts one cycle after a channel 1 match and ignores channel 0 matches.
- R4: With the mode bit set, the odd pin inverts one cycle after a channel 0 match or a channel 1 match. If both occur in the same cycle it inverts only once.
- R5: Control bit 0 enables channel 0 and control bit 1 enables channel 1. A disabled channel produces no match, no pin inversion and no flag.
- R6: A match requires the timer's count-enable strobe in that cycle. An equal count presented without the strobe causes no event.
- R7: After reset, both pins, both compare registers, the mode bit, the enable bits and the flags are 0.
- R8: Control bit 3 (channel 0) and control bit 4 (channel 1) are sticky match flags, set on every match of their channel. Writing 0 to a flag clears it and writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set. The irq output is the OR of the two flags.
- R9: A match against the old compare value in the same cycle as a write to that compare register still inverts the pin.
- R10: A control write loads control bit 5 into the even pin and control bit 6 into the odd pin, but only for a channel whose enable bit was 0 before the write. For an enabled channel these bits are ignored. When it applies, this load takes the place of a pin inversion in that cycle.
- R11: Reading address 2 returns the enables (bits 1:0), the mode (bit 2), the flags (bits 4:3), the even pin level (bit 5) and the odd pin level (bit 6), with zeros above. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| tmr_a_tick | input | 1 | Count-enable strobe of timer A |
| tmr_a_cnt | input | CNT_W | Count of timer A, compared by channel 0 |
| tmr_b_tick | input | 1 | Count-enable strobe of timer B |
| tmr_b_cnt | input | CNT_W | Count of timer B, compared by channel 1 |
| pin_even | output | 1 | Even output pin |
| pin_odd | output | 1 | Odd output pin |
| irq | output | 1 | Interrupt request, OR of the match flags |

## Verification
If a compare register, enable bit or mode bit holds a wrong value, the first qualifying timer event shows the error. The affected pin misses an inversion or inverts when it should not, and the pin level is visible one cycle after the event. A corrupted flag shows up at once on irq and in the control readback. The pins carry a toggle history, so an earlier missed or doubled inversion stays visible in their level on every later cycle until a preset reloads the pin. Because of this, the bench compares the pins against its model on every cycle and not only at events.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

   typedef enum logic [1:0] {
      ADR_CMP0 = 2'd0,
      ADR_CMP1 = 2'd1,
      ADR_CTRL = 2'd2,
      ADR_NONE = 2'd3
   } ocmp_adr_e;

   localparam int CB_EN0   = 0;
   localparam int CB_EN1   = 1;
   localparam int CB_MODE  = 2;
   localparam int CB_FLG0  = 3;
   localparam int CB_FLG1  = 4;
   localparam int CB_LVL0  = 5;
   localparam int CB_LVL1  = 6;
   localparam int CTRL_W   = 7;
   localparam int N_CH     = 2;

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cmp_q,
   output logic             hit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (wr_sel) cmp_q <= wr_data;
   end

   assign hit = en && tick && (cnt == cmp_q);

   p_no_hit_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !hit);
   p_need_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |-> !hit);
   p_write_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> cmp_q == $past(wr_data));

endmodule

// File: rtl/ocmp_pin.sv
module ocmp_pin #(
   parameter bit ODD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ld,
   input  logic ld_val,
   input  logic hit_own,
   input  logic hit_other,
   input  logic mode,
   output logic pin
);

   logic hit;

   generate
      if (ODD) begin : g_odd
         assign hit = mode ? (hit_own | hit_other) : hit_own;
      end else begin : g_even
         logic unused_ok;
         assign unused_ok = ^{hit_other, mode};
         assign hit = hit_own;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pin <= 1'b0;
      else if (ld)  pin <= ld_val;
      else if (hit) pin <= ~pin;
   end

   p_toggle_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && (hit_own || (ODD && mode && hit_other))) |=> pin != $past(pin));
   p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !hit_own && !(ODD && mode)) |=> $stable(pin));
   p_preset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> pin == $past(ld_val));

endmodule

// File: rtl/paired_ocmp.sv
module paired_ocmp #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic             tmr_a_tick,
   input  logic [CNT_W-1:0] tmr_a_cnt,
   input  logic             tmr_b_tick,
   input  logic [CNT_W-1:0] tmr_b_cnt,
   output logic             pin_even,
   output logic             pin_odd,
   output logic             irq
);
   import ocmp_pkg::*;

   localparam int PAD_W = CNT_W - CTRL_W;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("paired_ocmp: CNT_W must hold the control register");
      end
   endgenerate

   logic [N_CH-1:0]  en_q;
   logic             mode_q;
   logic [N_CH-1:0]  flag_q;
   logic [N_CH-1:0]  hit;
   logic [N_CH-1:0]  pin;
   logic [N_CH-1:0]  ld;
   logic [CNT_W-1:0] cmp_q [N_CH];
   logic [N_CH-1:0]  tick_v;
   logic [CNT_W-1:0] cnt_v [N_CH];
   logic             wr_ctrl;
   logic [CTRL_W-1:0] ctrl_rd;

   assign tick_v   = {tmr_b_tick, tmr_a_tick};
   assign cnt_v[0] = tmr_a_cnt;
   assign cnt_v[1] = tmr_b_cnt;
   assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ch
         ocmp_match #(.CNT_W(CNT_W)) i_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (wr_en && (wr_addr == 2'(g))),
            .wr_data(wr_data),
            .en     (en_q[g]),
            .tick   (tick_v[g]),
            .cnt    (cnt_v[g]),
            .cmp_q  (cmp_q[g]),
            .hit    (hit[g])
         );

         assign ld[g] = wr_ctrl && !en_q[g];

         ocmp_pin #(.ODD(g == 1)) i_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld       (ld[g]),
            .ld_val   (wr_data[CB_LVL0 + g]),
            .hit_own  (hit[g]),
            .hit_other(hit[1-g]),
            .mode     (mode_q),
            .pin      (pin[g])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_q[g] <= 1'b0;
            else if (hit[g])
               flag_q[g] <= 1'b1;
            else if (wr_ctrl && !wr_data[CB_FLG0 + g])
               flag_q[g] <= 1'b0;
         end

         p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> flag_q[g]);
         p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !wr_ctrl) |=> flag_q[g]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mode_q <= 1'b0;
      end else if (wr_ctrl) begin
         en_q   <= wr_data[CB_EN1:CB_EN0];
         mode_q <= wr_data[CB_MODE];
      end
   end

   assign ctrl_rd = {pin, flag_q, mode_q, en_q};

   always_comb begin
      unique case (ocmp_adr_e'(rd_addr))
         ADR_CMP0: rd_data = cmp_q[0];
         ADR_CMP1: rd_data = cmp_q[1];
         ADR_CTRL: rd_data = {{PAD_W{1'b0}}, ctrl_rd};
         default:  rd_data = '0;
      endcase
   end

   assign pin_even = pin[0];
   assign pin_odd  = pin[1];
   assign irq      = |flag_q;

   p_even_ignores_ch1_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[0] && !ld[0]) |=> $stable(pin_even));
   p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(hit[0] || hit[1]));

endmodule

// File: tb/test_paired_ocmp.sv
`timescale 1ns/100ps
module test_paired_ocmp;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         tmr_a_tick = 1'b0, tmr_b_tick = 1'b0;
   logic [W-1:0] tmr_a_cnt = '0, tmr_b_cnt = '0;
   logic         pin_even, pin_odd, irq;

   int n_vec = 0;
   int n_bad = 0;

   // model state
   logic [W-1:0] m_cmp0 = '0, m_cmp1 = '0;
   logic [1:0]   m_en = '0, m_flg = '0;
   logic         m_mode = 1'b0, m_p0 = 1'b0, m_p1 = 1'b0;

   always #2.5 clk = ~clk;

   paired_ocmp #(.CNT_W(W)) i_paired_ocmp (.*);

   function automatic logic [W-1:0] exp_rd(logic [1:0] a);
      case (a)
         2'd0: return m_cmp0;
         2'd1: return m_cmp1;
         2'd2: return W'({m_p1, m_p0, m_flg, m_mode, m_en});
         default: return '0;
      endcase
   endfunction

   task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(string tag, bit we, logic [1:0] wa, logic [W-1:0] wd,
                       bit ta, logic [W-1:0] ca, bit tb, logic [W-1:0] cb,
                       logic [1:0] ra);
      logic m0, m1, wc, ld0, ld1;
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd;
      tmr_a_tick = ta; tmr_a_cnt = ca; tmr_b_tick = tb; tmr_b_cnt = cb;
      rd_addr = ra;
      m0  = m_en[0] && ta && (ca == m_cmp0);
      m1  = m_en[1] && tb && (cb == m_cmp1);
      wc  = we && (wa == 2'd2);
      ld0 = wc && !m_en[0];
      ld1 = wc && !m_en[1];
      @(posedge clk);
      m_p0 = ld0 ? wd[5] : (m_p0 ^ m0);
      m_p1 = ld1 ? wd[6] : (m_p1 ^ (m_mode ? (m0 | m1) : m1));
      m_flg[0] = m0 | (m_flg[0] & (wc ? wd[3] : 1'b1));
      m_flg[1] = m1 | (m_flg[1] & (wc ? wd[4] : 1'b1));
      if (wc) begin m_en = wd[1:0]; m_mode = wd[2]; end
      if (we && wa == 2'd0) m_cmp0 = wd;
      if (we && wa == 2'd1) m_cmp1 = wd;
      #1;
      check({tag, " pin_even R2"}, W'(pin_even), W'(m_p0));
      check({tag, (m_mode ? " pin_odd R4" : " pin_odd R3")}, W'(pin_odd), W'(m_p1));
      check({tag, " irq R8"}, W'(irq), W'(|m_flg));
      check({tag, " rd R11"}, rd_data, exp_rd(ra));
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1;
      check("R7 pin_even reset", W'(pin_even), '0);
      check("R7 pin_odd reset", W'(pin_odd), '0);
      check("R7 irq reset", W'(irq), '0);
      @(negedge clk); rst_n = 1'b1;
      step("R7 cmp0", 0, 0, 0, 0, 0, 0, 0, 2'd0);
      step("R7 cmp1", 0, 0, 0, 0, 0, 0, 0, 2'd1);
      step("R7 ctrl", 0, 0, 0, 0, 0, 0, 0, 2'd2);
      // compare registers
      step("R1 wr cmp0", 1, 2'd0, 16'd5, 0, 0, 0, 0, 2'd0);
      step("R1 wr cmp1", 1, 2'd1, 16'd9, 0, 0, 0, 0, 2'd1);
      step("R11 addr3", 0, 0, 0, 0, 0, 0, 0, 2'd3);
      // disabled: equal counts do nothing
      step("R5 disabled", 0, 0, 0, 1, 16'd5, 1, 16'd9, 2'd2);
      // enable both, mode 0
      step("R5 enable", 1, 2'd2, 16'h0003, 0, 0, 0, 0, 2'd2);
      step("R2 ch0 hit", 0, 0, 0, 1, 16'd5, 0, 0, 2'd2);
      step("R6 held no tick", 0, 0, 0, 0, 16'd5, 0, 16'd9, 2'd2);
      step("R3 ch1 hit", 0, 0, 0, 0, 0, 1, 16'd9, 2'd2);
      step("R3 ch0 only", 0, 0, 0, 1, 16'd5, 0, 0, 2'd2);
      // mode 1, keep flags
      step("R4 mode1", 1, 2'd2, 16'h001F, 0, 0, 0, 0, 2'd2);
      step("R4 both same cycle", 0, 0, 0, 1, 16'd5, 1, 16'd9, 2'd2);
      step("R4 ch0 only", 0, 0, 0, 1, 16'd5, 0, 0, 2'd2);
      // write with simultaneous old match
      step("R9 write during hit", 1, 2'd0, 16'd7, 1, 16'd5, 0, 0, 2'd0);
      step("R9 old value gone", 0, 0, 0, 1, 16'd5, 0, 0, 2'd0);
      step("R1 new value", 0, 0, 0, 1, 16'd7, 0, 0, 2'd0);
      // flag clear, set wins
      step("R8 clear with hit", 1, 2'd2, 16'h0007, 1, 16'd7, 0, 0, 2'd2);
      step("R8 clear", 1, 2'd2, 16'h0007, 0, 0, 0, 0, 2'd2);
      // preset ignored while enabled
      step("R10 ignored", 1, 2'd2, 16'h0060, 0, 0, 0, 0, 2'd2);
      step("R5 now disabled", 0, 0, 0, 1, 16'd7, 1, 16'd9, 2'd2);
      step("R10 preset", 1, 2'd2, 16'h0060, 0, 0, 0, 0, 2'd2);
      step("R10 preset zero", 1, 2'd2, 16'h0000, 0, 0, 0, 0, 2'd2);
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] wa, ra;
         logic [W-1:0] wd;
         bit we;
         we = ($urandom % 6) == 0;
         wa = 2'($urandom % 4);
         wd = (wa == 2'd2) ? W'($urandom % 128) : W'($urandom % 4);
         ra = 2'($urandom % 4);
         step("RND", we, wa, wd,
              bit'($urandom % 2), W'($urandom % 4),
              bit'($urandom % 2), W'($urandom % 4), ra);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule